// File: doc/BRIEF.md
# Image Sensor Control Register Bank with Frame-Aligned Commit

This block holds the control registers of an image sensor core. A synchronous register port (8-bit address, 16-bit data, write and read strobes, read data returned one cycle later) lets a host program the bank. On the far side, the readout timing logic consumes an active copy of the exposure and geometry settings, a run/restart indication and per-colour signed calibration offsets.

Exposure and geometry settings are double-buffered. A host write lands in a staging copy and can be read back at once. The staging copy reaches the active copy only on a cycle where the timing generator pulses `frame_start` and the hold bit is clear, so a frame never sees a half-applied configuration. A commit state machine has three states. SYNC_CLEAN means staging equals active. SYNC_PENDING means a staged write is waiting for a frame boundary. SYNC_HELD means a staged write is frozen by the hold bit. Its transitions are:

- CLEAN→PENDING on a staged write.
- CLEAN→HELD on a staged write while hold is set.
- PENDING→HELD when hold is set.
- PENDING→CLEAN on a commit.
- PENDING→PENDING on a commit with a new write in the same cycle.
- HELD→PENDING when hold clears.

A second state machine governs readout. RUN_ACTIVE goes to RUN_HALTED when the enable bit clears. RUN_HALTED goes to RUN_RESTART when enable returns. RUN_RESTART is a one-cycle state that tells the timing generator to start a new frame at its first row. It then goes to RUN_ACTIVE, or back to RUN_HALTED if enable has cleared again. The red and blue offsets either track a calibration result supplied from outside or, in manual mode, hold a host-written value.

Top module: `sensor_regbank`

Register map (16-bit registers):

| Address | Contents |
|---|---|
| 0x07, 0xF8 | Control. Both addresses are the same state. Bit 0 is readout enable; bit 1 is hold. |
| 0x10..0x17 | Staged settings: window height, window width, horizontal blank, vertical blank, integration time, integration delay, skip/mirror, gain. |
| 0x60 | Calibration mode. Bit 0 = 1 selects manual mode. |
| 0x63 | Red offset. |
| 0x64 | Blue offset. |
| 0xFF | Version. |

## Requirements
- R1: After reset, the control register reads 0x0001 at both its addresses, the calibration mode register reads 0x0000, every active and staged setting is 0x0000, the stored offsets are 0x0020, `readout_run` is 1 and `readout_restart` is 0.
- R2: A write to a staged setting (0x10 to 0x17) is readable from that address on the next read. The matching `active_cfg` slice (setting i at bits 16*i+15:16*i) keeps its old value until a commit.
- R3: When `frame_start` is high in a cycle where hold (control bit 1) is 0 and a staged write is pending, every `active_cfg` slice equals the staged value after that clock edge. `active_cfg` changes on no other edge.
- R4: While hold is 1, `frame_start` commits nothing. After hold returns to 0, the next `frame_start` commits the staged values.
- R5: Writing the control register with bit 0 = 0 drives `readout_run` low on the second clock edge after the write. It stays low while bit 0 stays 0.
- R6: Writing bit 0 back to 1 raises `readout_restart` for exactly one cycle, starting at the second edge after the write. `readout_run` rises on the following edge.
- R7: Addresses 0x07 and 0xF8 hold the same control state: a write to either is read back from both. Bits 15:2 read as 0.
- R8: When calibration mode bit 0 is 0, writes to 0x63 and 0x64 are ignored. Reads return the matching 9-bit `cal_in` field, zero-extended. `ofs_out` equals `cal_in`.
- R9: When calibration mode bit 0 is 1, 0x63 and 0x64 store write-data bits 8:0. They read back as that value, zero-extended. The value drives `ofs_out` as a 9-bit two's-complement number with bit 8 as the sign (red at bits 8:0, blue at bits 17:9).
- R10: Address 0xFF reads 0x1621, and writes to it have no effect.
- R11: Reads from unmapped addresses return 0x0000, and writes to them change no register.
- R12: `reg_rdata` presents the addressed register on the clock edge that samples `reg_re` high, and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_we | input | 1 | Write strobe |
| reg_re | input | 1 | Read strobe |
| reg_rdata | output | 16 | Registered read data |
| frame_start | input | 1 | Frame boundary pulse from the timing generator |
| cal_in | input | 18 | Calibration results: red at 8:0, blue at 17:9 |
| ofs_out | output | 18 | Signed offsets in use: red at 8:0, blue at 17:9 |
| active_cfg | output | 128 | Active copies of the eight staged settings |
| readout_run | output | 1 | Readout running |
| readout_restart | output | 1 | One-cycle pulse to restart at the first row of a new frame |

## Verification
Read data is due one edge after the read strobe. The scoreboard driver queues each expected word when it issues a read, and the monitor compares it on the falling edge after the capturing edge. Active settings change on the edge that samples `frame_start`. `readout_run` falls on the second edge after a control write, and `readout_restart` appears on that same second edge and lasts one cycle. Offsets follow `cal_in` combinationally, or follow a manual write one edge later. Every direct check samples on a falling edge counted from the driving negedge, so no comparison races a register update.

// File: rtl/srb_pkg.sv
package srb_pkg;
    localparam int DW    = 16;
    localparam int AW    = 8;
    localparam int OFS_W = 9;

    localparam logic [AW-1:0] A_CTRL       = 8'h07;
    localparam logic [AW-1:0] A_CTRL_MIR   = 8'hF8;
    localparam logic [AW-1:0] A_STAGE_BASE = 8'h10;
    localparam logic [AW-1:0] A_CALMODE    = 8'h60;
    localparam logic [AW-1:0] A_OFS_BASE   = 8'h63;
    localparam logic [AW-1:0] A_VERSION    = 8'hFF;

    localparam logic [DW-1:0]    VERSION_ID = 16'h1621;
    localparam logic [OFS_W-1:0] OFS_RESET  = 9'h020;

    typedef enum logic [1:0] {
        SYNC_CLEAN   = 2'd0,
        SYNC_PENDING = 2'd1,
        SYNC_HELD    = 2'd2
    } sync_state_t;

    typedef enum logic [1:0] {
        RUN_ACTIVE  = 2'd0,
        RUN_HALTED  = 2'd1,
        RUN_RESTART = 2'd2
    } run_state_t;
endpackage

// File: rtl/srb_sync_fsm.sv
module srb_sync_fsm
    import srb_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int WIDTH    = 16
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [NUM_REGS-1:0]             stage_we,
    input  logic [WIDTH-1:0]                wdata,
    input  logic                            hold,
    input  logic                            frame_start,
    output logic [NUM_REGS-1:0][WIDTH-1:0]  staged_o,
    output logic [NUM_REGS-1:0][WIDTH-1:0]  active_o
);
    sync_state_t state_q, state_d;
    logic        any_we;
    logic        commit;
    logic [NUM_REGS-1:0][WIDTH-1:0] staged_q, active_q;

    assign any_we = |stage_we;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= SYNC_CLEAN;
        else     state_q <= state_d;
    end

    // next state and commit decision
    always_comb begin
        state_d = state_q;
        commit  = 1'b0;
        unique case (state_q)
            SYNC_CLEAN: begin
                if (any_we) state_d = hold ? SYNC_HELD : SYNC_PENDING;
            end
            SYNC_PENDING: begin
                if (hold) begin
                    state_d = SYNC_HELD;
                end else if (frame_start) begin
                    commit  = 1'b1;
                    state_d = any_we ? SYNC_PENDING : SYNC_CLEAN;
                end
            end
            SYNC_HELD: begin
                if (!hold) state_d = SYNC_PENDING;
            end
            default: state_d = SYNC_CLEAN;
        endcase
    end

    // staging and active copies
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                staged_q[i] <= '0;
                active_q[i] <= '0;
            end else begin
                if (stage_we[i]) staged_q[i] <= wdata;
                if (commit)      active_q[i] <= staged_q[i];
            end
        end
    end

    assign staged_o = staged_q;
    assign active_o = active_q;

    assert_no_commit_outside_frame_R3: assert property (@(posedge clk) disable iff (rst)
        !(frame_start && !hold) |=> $stable(active_q));

    assert_commit_copies_staged_R3: assert property (@(posedge clk) disable iff (rst)
        (frame_start && !hold && state_q == SYNC_PENDING) |=> (active_q == $past(staged_q)));

    assert_hold_freezes_R4: assert property (@(posedge clk) disable iff (rst)
        hold |=> $stable(active_q));
endmodule

// File: rtl/srb_run_fsm.sv
module srb_run_fsm
    import srb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic enable,
    output logic run_o,
    output logic restart_o
);
    run_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= RUN_ACTIVE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        run_o     = 1'b0;
        restart_o = 1'b0;
        unique case (state_q)
            RUN_ACTIVE: begin
                run_o = 1'b1;
                if (!enable) state_d = RUN_HALTED;
            end
            RUN_HALTED: begin
                if (enable) state_d = RUN_RESTART;
            end
            RUN_RESTART: begin
                restart_o = 1'b1;
                state_d   = enable ? RUN_ACTIVE : RUN_HALTED;
            end
            default: state_d = RUN_HALTED;
        endcase
    end

    assert_halt_follows_disable_R5: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !run_o);

    assert_restart_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        restart_o |=> !restart_o);

    assert_run_rises_after_restart_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(run_o) |-> $past(restart_o));
endmodule

// File: rtl/srb_offset.sv
module srb_offset
    import srb_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    manual,
    input  logic                    wr_hit,
    input  logic [OFS_W-1:0]        wdata,
    input  logic [OFS_W-1:0]        cal_val,
    output logic [OFS_W-1:0]        rd_val,
    output logic signed [OFS_W-1:0] value_o
);
    logic [OFS_W-1:0] stored_q;

    always_ff @(posedge clk) begin
        if (rst)                  stored_q <= OFS_RESET;
        else if (manual && wr_hit) stored_q <= wdata;
    end

    assign rd_val  = manual ? stored_q : cal_val;
    assign value_o = $signed(rd_val);

    assert_auto_ignores_write_R8: assert property (@(posedge clk) disable iff (rst)
        !manual |=> $stable(stored_q));

    assert_manual_write_lands_R9: assert property (@(posedge clk) disable iff (rst)
        (manual && wr_hit) |=> (stored_q == $past(wdata)));
endmodule

// File: rtl/sensor_regbank.sv
module sensor_regbank
    import srb_pkg::*;
#(
    parameter int NUM_STAGED = 8,
    parameter int NUM_OFS    = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [7:0]                  reg_addr,
    input  logic [15:0]                 reg_wdata,
    input  logic                        reg_we,
    input  logic                        reg_re,
    output logic [15:0]                 reg_rdata,
    input  logic                        frame_start,
    input  logic [NUM_OFS*9-1:0]        cal_in,
    output logic [NUM_OFS*9-1:0]        ofs_out,
    output logic [NUM_STAGED*16-1:0]    active_cfg,
    output logic                        readout_run,
    output logic                        readout_restart
);
    localparam int CTRL_BITS = 2;

    logic                   ctrl_hit, ver_hit, mode_hit, mapped;
    logic [NUM_STAGED-1:0]  stage_hit;
    logic [NUM_OFS-1:0]     ofs_hit;
    logic                   en_q, hold_q, manual_q;
    logic [DW-1:0]          rd_mux, rdata_q;

    logic [NUM_STAGED-1:0][DW-1:0] staged_w, active_w;
    logic [NUM_OFS-1:0][OFS_W-1:0] ofs_rd;
    logic signed [OFS_W-1:0]       ofs_val [NUM_OFS];

    // address decode
    assign ctrl_hit = (reg_addr == A_CTRL) || (reg_addr == A_CTRL_MIR);
    assign ver_hit  = (reg_addr == A_VERSION);
    assign mode_hit = (reg_addr == A_CALMODE);

    for (genvar i = 0; i < NUM_STAGED; i++) begin : g_shit
        assign stage_hit[i] = (reg_addr == A_STAGE_BASE + AW'(i));
    end
    for (genvar j = 0; j < NUM_OFS; j++) begin : g_ohit
        assign ofs_hit[j] = (reg_addr == A_OFS_BASE + AW'(j));
    end

    assign mapped = ctrl_hit | ver_hit | mode_hit | (|stage_hit) | (|ofs_hit);

    // control and mode bits
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q     <= 1'b1;
            hold_q   <= 1'b0;
            manual_q <= 1'b0;
        end else if (reg_we) begin
            if (ctrl_hit) begin
                en_q   <= reg_wdata[0];
                hold_q <= reg_wdata[1];
            end
            if (mode_hit) manual_q <= reg_wdata[0];
        end
    end

    srb_sync_fsm #(
        .NUM_REGS (NUM_STAGED),
        .WIDTH    (DW)
    ) u_sync (
        .clk         (clk),
        .rst         (rst),
        .stage_we    (stage_hit & {NUM_STAGED{reg_we}}),
        .wdata       (reg_wdata),
        .hold        (hold_q),
        .frame_start (frame_start),
        .staged_o    (staged_w),
        .active_o    (active_w)
    );

    srb_run_fsm u_run (
        .clk       (clk),
        .rst       (rst),
        .enable    (en_q),
        .run_o     (readout_run),
        .restart_o (readout_restart)
    );

    for (genvar j = 0; j < NUM_OFS; j++) begin : g_ofs
        srb_offset u_ofs (
            .clk     (clk),
            .rst     (rst),
            .manual  (manual_q),
            .wr_hit  (reg_we & ofs_hit[j]),
            .wdata   (reg_wdata[OFS_W-1:0]),
            .cal_val (cal_in[j*OFS_W +: OFS_W]),
            .rd_val  (ofs_rd[j]),
            .value_o (ofs_val[j])
        );
        assign ofs_out[j*OFS_W +: OFS_W] = ofs_val[j];
    end

    assign active_cfg = active_w;

    // read mux
    always_comb begin
        rd_mux = '0;
        if (ctrl_hit) rd_mux = {{(DW-CTRL_BITS){1'b0}}, hold_q, en_q};
        if (mode_hit) rd_mux = {{(DW-1){1'b0}}, manual_q};
        if (ver_hit)  rd_mux = VERSION_ID;
        for (int i = 0; i < NUM_STAGED; i++)
            if (stage_hit[i]) rd_mux = staged_w[i];
        for (int j = 0; j < NUM_OFS; j++)
            if (ofs_hit[j]) rd_mux = {{(DW-OFS_W){1'b0}}, ofs_rd[j]};
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata_q <= '0;
        else if (reg_re) rdata_q <= rd_mux;
    end

    assign reg_rdata = rdata_q;

    assert_version_constant_R10: assert property (@(posedge clk) disable iff (rst)
        (reg_re && reg_addr == A_VERSION) |=> (reg_rdata == VERSION_ID));

    assert_unmapped_reads_zero_R11: assert property (@(posedge clk) disable iff (rst)
        (reg_re && !mapped) |=> (reg_rdata == '0));

    assert_ctrl_upper_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (reg_re && ctrl_hit) |=> (reg_rdata[DW-1:CTRL_BITS] == '0));

    assert_rdata_holds_R12: assert property (@(posedge clk) disable iff (rst)
        !reg_re |=> $stable(reg_rdata));
endmodule

// File: tb/sensor_regbank_tb.sv
module sensor_regbank_tb;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [7:0]   reg_addr = '0;
    logic [15:0]  reg_wdata = '0;
    logic         reg_we = 1'b0;
    logic         reg_re = 1'b0;
    logic [15:0]  reg_rdata;
    logic         frame_start = 1'b0;
    logic [17:0]  cal_in;
    logic [17:0]  ofs_out;
    logic [127:0] active_cfg;
    logic         readout_run, readout_restart;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [15:0] exp_q[$];
    string       tag_q[$];
    logic        re_q = 1'b0;

    always #4 clk = ~clk;

    sensor_regbank u_dut (
        .clk             (clk),
        .rst             (rst),
        .reg_addr        (reg_addr),
        .reg_wdata       (reg_wdata),
        .reg_we          (reg_we),
        .reg_re          (reg_re),
        .reg_rdata       (reg_rdata),
        .frame_start     (frame_start),
        .cal_in          (cal_in),
        .ofs_out         (ofs_out),
        .active_cfg      (active_cfg),
        .readout_run     (readout_run),
        .readout_restart (readout_restart)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops one expected word per captured read
    always @(posedge clk) re_q <= reg_re;
    always @(negedge clk) begin
        if (re_q && !rst) begin
            if (exp_q.size() == 0) begin
                check("R12 unexpected read", 32'(reg_rdata), 32'hFFFF_FFFF);
            end else begin
                check(tag_q.pop_front(), 32'(reg_rdata), 32'(exp_q.pop_front()));
            end
        end
    end

    // driver tasks, called at a falling edge
    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [15:0] e, input string tag);
        exp_q.push_back(e); tag_q.push_back(tag);
        reg_addr = a; reg_re = 1'b1;
        @(negedge clk);
        reg_re = 1'b0;
    endtask

    task automatic frame();
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        cal_in = {9'h011, 9'h1E7};
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 run after reset", 32'(readout_run), 32'd1);
        check("R1 restart idle", 32'(readout_restart), 32'd0);
        check("R1 active zero", 32'(active_cfg[31:0]), 32'd0);
        rd(8'h07, 16'h0001, "R1 ctrl reset");
        rd(8'hF8, 16'h0001, "R1 mirror reset");
        rd(8'h60, 16'h0000, "R1 mode reset");
        rd(8'h15, 16'h0000, "R1 staged reset");

        // R8 auto mode
        check("R8 red tracks cal", 32'(ofs_out[8:0]), 32'h1E7);
        check("R8 blue tracks cal", 32'(ofs_out[17:9]), 32'h011);
        rd(8'h63, 16'h01E7, "R8 red read cal");
        wr(8'h63, 16'h0055);
        cal_in = {9'h0F0, 9'h003};
        @(negedge clk);
        check("R8 red follows new cal", 32'(ofs_out[8:0]), 32'h003);
        rd(8'h64, 16'h00F0, "R8 blue read cal");

        // R9 manual mode; R1 stored reset shows the auto write was ignored (R8)
        wr(8'h60, 16'h0001);
        check("R1 R8 red stored default", 32'(ofs_out[8:0]), 32'h020);
        rd(8'h63, 16'h0020, "R8 auto write ignored");
        wr(8'h63, 16'h01F0);
        check("R9 red negative", 32'($signed(ofs_out[8:0])), 32'(-16));
        wr(8'h64, 16'hFE7F);
        check("R9 blue positive", 32'($signed(ofs_out[17:9])), 32'd127);
        rd(8'h63, 16'h01F0, "R9 red readback");
        rd(8'h64, 16'h007F, "R9 blue readback");

        // R2, R3 staging and commit
        wr(8'h10, 16'hA5A5);
        wr(8'h17, 16'h1234);
        rd(8'h10, 16'hA5A5, "R2 staged readback");
        check("R2 active unchanged", 32'(active_cfg[15:0]), 32'h0);
        idle(2);
        check("R3 no commit without frame", 32'(active_cfg[127:112]), 32'h0);
        frame();
        check("R3 commit slot0", 32'(active_cfg[15:0]), 32'hA5A5);
        check("R3 commit slot7", 32'(active_cfg[127:112]), 32'h1234);

        // R4 hold, R7 mirror
        wr(8'h07, 16'hFFFF);
        rd(8'hF8, 16'h0003, "R7 mirror sees ctrl write");
        wr(8'h12, 16'h0BAD);
        frame();
        check("R4 held no commit", 32'(active_cfg[47:32]), 32'h0);
        wr(8'hF8, 16'h0001);
        rd(8'h07, 16'h0001, "R7 ctrl sees mirror write");
        check("R4 not yet committed", 32'(active_cfg[47:32]), 32'h0);
        frame();
        check("R4 commit after release", 32'(active_cfg[47:32]), 32'h0BAD);

        // R5, R6 readout halt and restart
        wr(8'h07, 16'h0000);
        check("R5 run still high", 32'(readout_run), 32'd1);
        @(negedge clk);
        check("R5 run low", 32'(readout_run), 32'd0);
        idle(3);
        check("R5 stays halted", 32'(readout_run), 32'd0);
        wr(8'hF8, 16'h0001);
        check("R6 no early restart", 32'(readout_restart), 32'd0);
        @(negedge clk);
        check("R6 restart pulse", 32'(readout_restart), 32'd1);
        check("R6 run low during restart", 32'(readout_run), 32'd0);
        @(negedge clk);
        check("R6 restart one cycle", 32'(readout_restart), 32'd0);
        check("R6 run resumes", 32'(readout_run), 32'd1);

        // R10 version, R11 unmapped
        wr(8'hFF, 16'h0000);
        rd(8'hFF, 16'h1621, "R10 version");
        wr(8'h50, 16'hBEEF);
        rd(8'h50, 16'h0000, "R11 unmapped read");
        rd(8'h07, 16'h0001, "R11 ctrl untouched");
        rd(8'h10, 16'hA5A5, "R11 staged untouched");

        // R12 rdata holds without read
        idle(2);
        check("R12 rdata held", 32'(reg_rdata), 32'hA5A5);
        check("R12 queue drained", 32'(exp_q.size()), 32'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule